// File: doc/BRIEF.md
# Receive Frame Header Checker

This block stands between a receive frame store and the host read port. When told to scan, it pulls one beat from the store and looks at the low byte. That byte is a marker saying whether a frame is waiting, whether the store is empty, or whether the store is corrupt. For each waiting frame the block gathers a 16-bit status word and a 16-bit length word. From these it decides whether to hand the payload to the host or to throw the frame away.

Good payloads pass through unchanged on a ready/valid stream that flags the final beat. A discarded frame is still read out of the store, using the same number of beats, so that the next frame lines up. The beat width is set by an access-mode input: 8, 16 or 32 bits per beat. Error classes are tallied in saturating counters. Two conditions stop the block and request a device reset: a corrupt marker and an oversized length.

Scanning continues frame after frame. It stops when the store reports empty or when a reset is requested.

Top module: `rxh_frame_checker`

## Requirements
- R1: A marker low byte of 0x00 ends the scan. The block goes idle (busy low) and pulls no further beats from the store until the next scan_go pulse.
- R2: A marker low byte of 0x01 starts header collection. The marker is one beat and bits 31:8 of that beat are ignored.
- R3: A marker low byte above 0x01 raises reset_req. reset_req then stays high, and the block pulls no beat, until rst.
- R4: acc_mode selects how the header arrives. 2'b00 (byte) uses four beats whose bits 7:0 carry, in order, status[7:0], status[15:8], length[7:0] and length[15:8]. 2'b01 (half-word) uses two beats whose bits 15:0 carry status and then length. 2'b10 (word) uses one beat with status in bits 15:0 and length in bits 31:16. 2'b11 behaves as byte mode. Unused upper bits are ignored.
- R5: The payload of an accepted frame takes ceil(length/1), ceil(length/2) or ceil(length/4) beats in byte, half-word or word mode. Each beat appears on pay_data unchanged, in order, and pay_last is high on the final beat only.
- R6: A length below 64 is a runt. The frame is discarded and cnt_runt increments.
- R7: A length above MAX_LEN increments cnt_long and raises reset_req right after the header, and no payload beat is pulled. Status-bit counters still apply to such a frame.
- R8: A frame whose status has any bit of mask 0xBF00 set is discarded. Status bit 8 increments cnt_fifo, bit 9 increments cnt_crc and bit 15 increments cnt_lenerr. Status bits 14 and 7:0 have no effect.
- R9: A discarded frame is drained with the same beat count as R5 and produces no pay_valid. Exactly one single-cycle drop_pulse is produced for it.
- R10: After each delivered or drained frame, the block reads the next marker without a new scan_go.
- R11: Each counter is CNT_W bits wide, holds at all-ones instead of wrapping, and clears only on rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_mode | input | 2 | Beat width: 00 byte, 01 half-word, 10 word, 11 byte |
| scan_go | input | 1 | Pulse that starts a scan while idle |
| buf_data | input | 32 | Beat from the frame store |
| buf_valid | input | 1 | Store beat available |
| buf_ready | output | 1 | Block takes the store beat this cycle |
| pay_data | output | 32 | Payload beat to host |
| pay_valid | output | 1 | Payload beat valid |
| pay_ready | input | 1 | Host accepts payload beat |
| pay_last | output | 1 | Final payload beat of the frame |
| drop_pulse | output | 1 | One-cycle pulse per discarded frame |
| reset_req | output | 1 | Sticky fatal flag requesting device reset |
| busy | output | 1 | Scan in progress |
| cnt_runt | output | CNT_W | Runt frame count |
| cnt_long | output | CNT_W | Oversized frame count |
| cnt_fifo | output | CNT_W | Status FIFO-error count |
| cnt_crc | output | CNT_W | Status CRC-error count |
| cnt_lenerr | output | CNT_W | Status length-error count |

## Verification
The bench builds the block with MAX_LEN of 200 and CNT_W of 6. The small MAX_LEN puts both the boundary length of 200 and an oversized length of 201 within a few dozen beats. The 6-bit counters make saturation reachable: a burst of seventy zero-length runts in word mode drives cnt_runt past 63 in a few hundred cycles. All four access-mode codes are used, with odd lengths that leave partial final beats and random stalls on both the store and host sides.

// File: rtl/rxh_pkg.sv
package rxh_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_RSVD = 2'b11
    } acc_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MARK,
        ST_HDR,
        ST_PAY,
        ST_DRAIN,
        ST_HALT
    } scan_st_e;

    typedef struct packed {
        logic [15:0] len;
        logic [15:0] status;
    } frame_hdr_t;

    localparam logic [7:0]  MARK_EMPTY      = 8'h00;
    localparam logic [7:0]  MARK_READY      = 8'h01;
    localparam logic [15:0] STATUS_BAD_MASK = 16'hBF00;
    localparam logic [15:0] RUNT_LIMIT      = 16'd64;
    localparam int STAT_FIFO_BIT   = 8;
    localparam int STAT_CRC_BIT    = 9;
    localparam int STAT_LENERR_BIT = 15;

    localparam int CNT_RUNT   = 0;
    localparam int CNT_LONG   = 1;
    localparam int CNT_FIFO   = 2;
    localparam int CNT_CRC    = 3;
    localparam int CNT_LENERR = 4;
    localparam int NUM_CNT    = 5;

    // index of the final header beat for a mode
    function automatic logic [1:0] hdr_last_idx(acc_mode_e m);
        case (m)
            ACC_HALF: return 2'd1;
            ACC_WORD: return 2'd0;
            default:  return 2'd3;
        endcase
    endfunction

    // beats needed to move len bytes at the given beat width
    function automatic logic [15:0] payload_beats(acc_mode_e m, logic [15:0] len);
        logic [16:0] l;
        l = {1'b0, len};
        case (m)
            ACC_HALF: return 16'((l + 17'd1) >> 1);
            ACC_WORD: return 16'((l + 17'd3) >> 2);
            default:  return len;
        endcase
    endfunction

endpackage

// File: rtl/rxh_hdr_asm.sv
module rxh_hdr_asm
    import rxh_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  acc_mode_e   mode,
    input  logic        beat_en,
    input  logic [31:0] beat_data,
    output logic        last_beat,
    output frame_hdr_t  hdr_now
);

    logic [1:0]  idx;
    logic [31:0] acc_q;
    logic [31:0] acc_n;

    assign last_beat = (idx == hdr_last_idx(mode));

    always_comb begin
        acc_n = acc_q;
        case (mode)
            ACC_HALF: begin
                if (idx == 2'd0) acc_n[15:0]  = beat_data[15:0];
                else             acc_n[31:16] = beat_data[15:0];
            end
            ACC_WORD: acc_n = beat_data;
            default:  acc_n[{idx, 3'b000} +: 8] = beat_data[7:0];
        endcase
    end

    assign hdr_now = frame_hdr_t'(acc_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= 2'd0;
            acc_q <= '0;
        end else if (beat_en) begin
            acc_q <= acc_n;
            idx   <= last_beat ? 2'd0 : idx + 2'd1;
        end
    end

endmodule

// File: rtl/rxh_sat_cnt.sv
module rxh_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/rxh_beat_ctr.sv
module rxh_beat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         at_last
);

    logic [W-1:0] rem;

    assign at_last = (rem == W'(1));

    always_ff @(posedge clk) begin
        if (rst)       rem <= '0;
        else if (load) rem <= load_val;
        else if (dec)  rem <= rem - 1'b1;
    end

endmodule

// File: rtl/rxh_frame_checker.sv
module rxh_frame_checker
    import rxh_pkg::*;
#(
    parameter int MAX_LEN = 1536,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       acc_mode,
    input  logic             scan_go,
    input  logic [31:0]      buf_data,
    input  logic             buf_valid,
    output logic             buf_ready,
    output logic [31:0]      pay_data,
    output logic             pay_valid,
    input  logic             pay_ready,
    output logic             pay_last,
    output logic             drop_pulse,
    output logic             reset_req,
    output logic             busy,
    output logic [CNT_W-1:0] cnt_runt,
    output logic [CNT_W-1:0] cnt_long,
    output logic [CNT_W-1:0] cnt_fifo,
    output logic [CNT_W-1:0] cnt_crc,
    output logic [CNT_W-1:0] cnt_lenerr
);

    localparam int          LEN_W = 16;
    localparam logic [LEN_W-1:0] MAX_LEN_W = LEN_W'(MAX_LEN);

    scan_st_e   st, st_n;
    acc_mode_e  mode;
    logic       take;
    logic       hdr_last, hdr_done, beat_last;
    frame_hdr_t hdr;
    logic       is_long, is_runt, bad_stat, discard;
    logic [LEN_W-1:0] beats;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];

    assign mode = acc_mode_e'(acc_mode);

    always_comb begin
        case (st)
            ST_MARK, ST_HDR, ST_DRAIN: buf_ready = 1'b1;
            ST_PAY:                    buf_ready = pay_ready;
            default:                   buf_ready = 1'b0;
        endcase
    end

    assign take      = buf_valid & buf_ready;
    assign pay_valid = (st == ST_PAY) & buf_valid;
    assign pay_data  = buf_data;
    assign pay_last  = pay_valid & beat_last;
    assign reset_req = (st == ST_HALT);
    assign busy      = (st != ST_IDLE) && (st != ST_HALT);

    rxh_hdr_asm u_hdr (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .beat_en   (take && st == ST_HDR),
        .beat_data (buf_data),
        .last_beat (hdr_last),
        .hdr_now   (hdr)
    );

    assign hdr_done = (st == ST_HDR) && take && hdr_last;
    assign is_long  = hdr.len > MAX_LEN_W;
    assign is_runt  = hdr.len < RUNT_LIMIT;
    assign bad_stat = |(hdr.status & STATUS_BAD_MASK);
    assign discard  = is_runt | bad_stat;
    assign beats    = payload_beats(mode, hdr.len);

    rxh_beat_ctr #(.W(LEN_W)) u_beats (
        .clk      (clk),
        .rst      (rst),
        .load     (hdr_done),
        .load_val (beats),
        .dec      (take && (st == ST_PAY || st == ST_DRAIN)),
        .at_last  (beat_last)
    );

    always_comb begin
        st_n = st;
        case (st)
            ST_IDLE: if (scan_go) st_n = ST_MARK;
            ST_MARK: if (take) begin
                if (buf_data[7:0] == MARK_EMPTY)      st_n = ST_IDLE;
                else if (buf_data[7:0] == MARK_READY) st_n = ST_HDR;
                else                                  st_n = ST_HALT;
            end
            ST_HDR: if (hdr_done) begin
                if (is_long)              st_n = ST_HALT;
                else if (beats == '0)     st_n = ST_MARK;
                else if (discard)         st_n = ST_DRAIN;
                else                      st_n = ST_PAY;
            end
            ST_PAY, ST_DRAIN: if (take && beat_last) st_n = ST_MARK;
            ST_HALT: st_n = ST_HALT;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            drop_pulse <= 1'b0;
        end else begin
            st         <= st_n;
            drop_pulse <= hdr_done && !is_long && discard;
        end
    end

    assign cnt_inc[CNT_RUNT]   = hdr_done && !is_long && is_runt;
    assign cnt_inc[CNT_LONG]   = hdr_done && is_long;
    assign cnt_inc[CNT_FIFO]   = hdr_done && hdr.status[STAT_FIFO_BIT];
    assign cnt_inc[CNT_CRC]    = hdr_done && hdr.status[STAT_CRC_BIT];
    assign cnt_inc[CNT_LENERR] = hdr_done && hdr.status[STAT_LENERR_BIT];

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        rxh_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .inc (cnt_inc[g]),
            .cnt (cnt_val[g])
        );
    end

    assign cnt_runt   = cnt_val[CNT_RUNT];
    assign cnt_long   = cnt_val[CNT_LONG];
    assign cnt_fifo   = cnt_val[CNT_FIFO];
    assign cnt_crc    = cnt_val[CNT_CRC];
    assign cnt_lenerr = cnt_val[CNT_LENERR];

endmodule

// File: rtl/rxh_frame_checker_sva.sv
module rxh_frame_checker_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             reset_req,
    input logic             buf_valid,
    input logic             buf_ready,
    input logic             pay_valid,
    input logic             pay_ready,
    input logic             drop_pulse,
    input logic [CNT_W-1:0] cnt_runt
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    AST_FATAL_STICKY:  assert property (@(posedge clk) disable iff (rst) reset_req |=> reset_req); // R3
    AST_FATAL_NO_READ: assert property (@(posedge clk) disable iff (rst) reset_req |-> !buf_ready); // R3
    AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (rst) !busy |-> (!buf_ready && !pay_valid)); // R1
    AST_PAY_FROM_BUF:  assert property (@(posedge clk) disable iff (rst) pay_valid |-> (buf_valid && buf_ready == pay_ready)); // R5
    AST_DROP_SINGLE:   assert property (@(posedge clk) disable iff (rst) drop_pulse |=> !drop_pulse); // R9
    AST_DROP_NO_PAY:   assert property (@(posedge clk) disable iff (rst) drop_pulse |-> !pay_valid); // R9
    AST_CNT_MONO:      assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> cnt_runt >= $past(cnt_runt)); // R11
    AST_CNT_SAT_HOLD:  assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(cnt_runt) == CNT_TOP) |-> cnt_runt == CNT_TOP); // R11

endmodule

bind rxh_frame_checker rxh_frame_checker_sva #(.CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .reset_req  (reset_req),
    .buf_valid  (buf_valid),
    .buf_ready  (buf_ready),
    .pay_valid  (pay_valid),
    .pay_ready  (pay_ready),
    .drop_pulse (drop_pulse),
    .cnt_runt   (cnt_runt)
);

// File: tb/tb_rxh_frame_checker.sv
module tb_rxh_frame_checker;

    localparam int MAX_LEN = 200;
    localparam int CNT_W   = 6;
    localparam int CMAX    = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       acc_mode = 2'b00;
    logic             scan_go = 1'b0;
    logic [31:0]      buf_data = '0;
    logic             buf_valid = 1'b0;
    logic             buf_ready;
    logic [31:0]      pay_data;
    logic             pay_valid;
    logic             pay_ready = 1'b0;
    logic             pay_last;
    logic             drop_pulse;
    logic             reset_req;
    logic             busy;
    logic [CNT_W-1:0] cnt_runt, cnt_long, cnt_fifo, cnt_crc, cnt_lenerr;

    rxh_frame_checker #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .acc_mode(acc_mode), .scan_go(scan_go),
        .buf_data(buf_data), .buf_valid(buf_valid), .buf_ready(buf_ready),
        .pay_data(pay_data), .pay_valid(pay_valid), .pay_ready(pay_ready),
        .pay_last(pay_last), .drop_pulse(drop_pulse), .reset_req(reset_req),
        .busy(busy), .cnt_runt(cnt_runt), .cnt_long(cnt_long),
        .cnt_fifo(cnt_fifo), .cnt_crc(cnt_crc), .cnt_lenerr(cnt_lenerr)
    );

    always #5 clk = ~clk;

    logic [31:0] bq[$];
    logic [32:0] eq[$];
    int n_chk = 0, n_fail = 0;
    int e_runt = 0, e_long = 0, e_fifo = 0, e_crc = 0, e_lenerr = 0;
    int e_drops = 0, seen_drops = 0;
    bit exp_fatal = 0;
    bit stall_en = 0;
    bit stall;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    function automatic int exp_beats(input int mode, input int len);
        if (mode == 1) return (len + 1) / 2;
        if (mode == 2) return (len + 3) / 4;
        return len;
    endfunction

    // store-side driver and host-side monitor
    always @(negedge clk) begin
        logic [32:0] e;
        stall     = stall_en && ($urandom % 4 == 0);
        buf_valid = (bq.size() > 0) && !stall;
        buf_data  = buf_valid ? bq[0] : $urandom;
        pay_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
        #1;
        if (!rst) begin
            if (drop_pulse) seen_drops++;
            if (pay_valid && pay_ready) begin
                if (eq.size() == 0) chk(0, "R5 unexpected payload", {31'd0, pay_last, pay_data}, 0);
                else begin
                    e = eq.pop_front();
                    chk({pay_last, pay_data} == e, "R5 payload beat", {31'd0, pay_last, pay_data}, {31'd0, e});
                end
            end
            if (buf_valid && buf_ready) void'(bq.pop_front());
        end
    end

    task automatic push_marker(input logic [7:0] m);
        logic [31:0] r;
        r = $urandom;
        bq.push_back({r[31:8], m});
    endtask

    task automatic push_frame(input int mode, input logic [15:0] st, input logic [15:0] len);
        logic [31:0] r, d;
        bit lng, runt, bad;
        int nb;
        lng  = int'(len) > MAX_LEN;
        runt = len < 16'd64;
        bad  = runt || ((st & 16'hBF00) != 0);
        push_marker(8'h01);
        r = $urandom;
        case (mode)
            1: begin
                bq.push_back({r[31:16], st});
                bq.push_back({r[15:0], len});
            end
            2: bq.push_back({len, st});
            default: begin
                bq.push_back({r[31:8], st[7:0]});
                bq.push_back({r[23:0], st[15:8]});
                bq.push_back({r[31:8], len[7:0]});
                bq.push_back({r[27:4], len[15:8]});
            end
        endcase
        if (st[8])  e_fifo   = sat(e_fifo);
        if (st[9])  e_crc    = sat(e_crc);
        if (st[15]) e_lenerr = sat(e_lenerr);
        if (lng) begin
            e_long = sat(e_long);
            exp_fatal = 1;
            return;
        end
        if (runt) e_runt = sat(e_runt);
        if (bad) e_drops++;
        nb = exp_beats(mode, int'(len));
        for (int i = 0; i < nb; i++) begin
            d = $urandom;
            bq.push_back(d);
            if (!bad) eq.push_back({(i == nb - 1), d});
        end
    endtask

    task automatic do_reset();
        @(negedge clk); #2;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        bq.delete(); eq.delete();
        e_runt = 0; e_long = 0; e_fifo = 0; e_crc = 0; e_lenerr = 0;
        e_drops = 0; seen_drops = 0; exp_fatal = 0;
        rst = 1'b0;
        @(negedge clk); #2;
        chk(cnt_runt == 0 && cnt_long == 0 && cnt_fifo == 0 && cnt_crc == 0 && cnt_lenerr == 0,
            "R11 counters cleared by reset", {cnt_runt, cnt_long, cnt_fifo, cnt_crc, cnt_lenerr}, 0);
        chk(reset_req == 0 && busy == 0, "R3 reset clears fatal", {reset_req, busy}, 0);
    endtask

    task automatic run_scan(input int mode, input bit add_end);
        int n;
        acc_mode = 2'(mode);
        if (add_end && !exp_fatal) push_marker(8'h00);
        @(negedge clk); #2; scan_go = 1'b1;
        @(negedge clk); #2; scan_go = 1'b0;
        n = 0;
        while (busy && n < 30000) begin
            @(negedge clk); #2;
            n++;
        end
        repeat (2) @(negedge clk);
        #2;
        chk(cnt_runt == CNT_W'(e_runt), "R6 runt count", cnt_runt, e_runt);
        chk(cnt_long == CNT_W'(e_long), "R7 long count", cnt_long, e_long);
        chk(cnt_fifo == CNT_W'(e_fifo), "R8 fifo count", cnt_fifo, e_fifo);
        chk(cnt_crc == CNT_W'(e_crc), "R8 crc count", cnt_crc, e_crc);
        chk(cnt_lenerr == CNT_W'(e_lenerr), "R8 lenerr count", cnt_lenerr, e_lenerr);
        chk(seen_drops == e_drops, "R9 drop pulses", seen_drops, e_drops);
        chk(reset_req == exp_fatal, "R3/R7 reset_req", reset_req, exp_fatal);
        chk(eq.size() == 0, "R5 payload all delivered", eq.size(), 0);
        if (!exp_fatal) chk(bq.size() == 0, "R10 store fully consumed", bq.size(), 0);
        else begin
            chk(busy == 0, "R3 halted not busy", busy, 0);
            do_reset();
        end
    endtask

    function automatic logic [15:0] rand_status();
        logic [15:0] s;
        s = 16'($urandom);
        if ($urandom % 3 != 0) s = s & 16'h40FF;
        return s;
    endfunction

    function automatic logic [15:0] rand_len();
        if ($urandom % 5 == 0) return 16'($urandom % 64);
        return 16'(64 + $urandom % (MAX_LEN - 63));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        #2;
        chk(busy == 0 && reset_req == 0 && buf_ready == 0 && pay_valid == 0,
            "R1 reset state quiet", {busy, reset_req, buf_ready, pay_valid}, 0);
        chk(cnt_runt == 0 && cnt_lenerr == 0, "R11 counters zero at reset", {cnt_runt, cnt_lenerr}, 0);
        rst = 1'b0;

        // byte mode: two good frames then empty marker (R2 R4 R5 R10)
        push_frame(0, 16'h0000, 16'd64);
        push_frame(0, 16'h0000, 16'd65);
        run_scan(0, 1);

        // R1: store beat left after idle is not pulled
        push_marker(8'h01);
        repeat (10) @(negedge clk);
        #2;
        chk(bq.size() == 1 && busy == 0, "R1 idle pulls nothing", bq.size(), 1);
        bq.delete();

        // half-word mode: odd length, runt, harmless status bits (R6 R8)
        stall_en = 1;
        push_frame(1, 16'h0000, 16'd101);
        push_frame(1, 16'h0000, 16'd63);
        push_frame(1, 16'h40FF, 16'd77);
        run_scan(1, 1);

        // word mode: boundary length, zero length runt, all error bits (R5 R6 R8 R9)
        push_frame(2, 16'h0000, 16'd200);
        push_frame(2, 16'h0000, 16'd0);
        push_frame(2, 16'h8300, 16'd90);
        push_frame(2, 16'h0400, 16'd70);
        run_scan(2, 1);

        // reserved mode acts as byte (R4)
        push_frame(3, 16'h0000, 16'd66);
        push_frame(3, 16'h0200, 16'd67);
        run_scan(3, 1);

        // oversized frame halts (R7)
        push_frame(2, 16'h0100, 16'd150);
        push_frame(2, 16'h8000, 16'd201);
        run_scan(2, 0);

        // corrupt marker halts (R3)
        push_frame(1, 16'h0000, 16'd80);
        push_marker(8'h80);
        exp_fatal = 1;
        run_scan(1, 0);

        // random scans
        for (int s = 0; s < 24; s++) begin
            int m, nf;
            m  = $urandom % 4;
            nf = 1 + $urandom % 4;
            for (int f = 0; f < nf; f++) push_frame(m, rand_status(), rand_len());
            run_scan(m, 1);
        end

        // saturation of runt counter (R11)
        stall_en = 0;
        for (int f = 0; f < 70; f++) push_frame(2, 16'h0000, 16'd0);
        run_scan(2, 1);
        chk(cnt_runt == CNT_W'(CMAX), "R11 runt counter saturates", cnt_runt, CMAX);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule